// File: doc/BRIEF.md
# Vector Integer Divide and Remainder Unit

This block computes integer quotients and remainders across a 128-bit vector. It takes two 128-bit source vectors and an 11-bit extended opcode. The opcode gives the lane size: four 32-bit words, two 64-bit doublewords, or one 128-bit quadword. It also selects signed or unsigned arithmetic and one of three operations: plain divide, extended divide, or remainder. Extended divide uses a dividend of twice the lane width, with the source-A element in the upper half and zeros in the lower half. Only the low lane-width bits of that quotient are returned.

All lanes share one radix-2 restoring divider, which retires one quotient bit per clock. The lanes are processed in turn, starting at lane 0. Signed operands are converted to sign-magnitude form and divided as unsigned numbers. The quotient is negated when the operand signs differ. The remainder takes the sign of the dividend. A zero divisor, or the most-negative value divided by -1 in signed mode, does not reach the divider. That lane gets a fixed result instead.

The control FSM has five states:
- `S_IDLE`: waits for `start`. A legal opcode moves it to `S_SETUP`; an unsupported opcode moves it to `S_DONE`.
- `S_SETUP`: prepares the current lane. A lane with a fixed result goes to `S_WRITE`; any other lane loads the divider and goes to `S_ITER`.
- `S_ITER`: holds while the divider runs and moves to `S_WRITE` when the divider finishes.
- `S_WRITE`: merges the lane result into the output vector. It returns to `S_SETUP` for the next lane, or goes to `S_DONE` after the last lane.
- `S_DONE`: raises `done` for one cycle and returns to `S_IDLE`.

Top module: `vdiv_unit`

## Requirements
- R1: The extended opcode is decoded as follows:
  - bits 5:0 must equal 001011;
  - bits 7:6 select the lane width: 10 = 32-bit, 11 = 64-bit, 00 = 128-bit;
  - bit 8 set selects signed arithmetic;
  - bits 10:9 select the operation: 00 = divide, 01 = extended divide, 11 = remainder.
  Lane i occupies result bits [i*W +: W], where W is the lane width.
- R2: An opcode with bits 10:9 = 10, bits 7:6 = 01, or bits 5:0 other than 001011 is unsupported. It raises `done` on the cycle after `start`, with `illegal` high and `result` zero.
- R3: Unsigned divide gives floor(A/B) in each lane. Unsigned remainder gives A mod B in each lane.
- R4: Signed divide truncates toward zero. A signed remainder takes the sign of the dividend.
- R5: Extended divide returns the low W bits of (A·2^W)/B, in both signed and unsigned modes. A quotient wider than W bits is truncated.
- R6: When the divisor is zero, or in signed mode when the dividend is the most-negative value and the divisor is -1, divide returns the A element and remainder returns zero. This applies at every lane width.
- R7: Under the same conditions, extended divide returns zero for a 32-bit lane and the A element for 64-bit and 128-bit lanes.
- R8: `start` is taken only while `busy` is low, and `busy` rises on the next cycle. A `start` pulse while `busy` is high changes neither the operation nor its result. `done` lasts one cycle. `result` holds its value while the unit is idle.
- R9: After reset, `busy`, `done` and `illegal` are low and `result` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (sampled when `busy` is low) |
| ext_op | input | 11 | Extended opcode |
| src_a | input | 128 | Dividend vector |
| src_b | input | 128 | Divisor vector |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Last opcode was unsupported |
| result | output | 128 | Quotient or remainder vector |

## Verification
The assertions check the handshake on every cycle:
- `done` lasts one cycle;
- `busy` follows an accepted `start`;
- `result` stays stable while idle;
- an unsupported opcode completes on the next cycle with a zero result.

Inside the divider they check that the partial remainder stays below the divisor, and that a zero divisor never reaches the divider. Lane values cannot be checked by properties. Only the bench's scenarios show them: signed rounding, extended-divide truncation, the fixed special-case results at each width, and lane placement. Those scenarios compare the outputs with quotients and remainders computed independently in the bench.

// File: rtl/vdiv_pkg.sv
package vdiv_pkg;
    typedef enum logic [1:0] {LW_WORD, LW_DWORD, LW_QUAD} lane_w_e;
    typedef enum logic [1:0] {OP_DIV, OP_DIVE, OP_MOD} op_kind_e;
    typedef enum logic [2:0] {S_IDLE, S_SETUP, S_ITER, S_WRITE, S_DONE} state_e;
endpackage

// File: rtl/vdiv_decode.sv
module vdiv_decode
    import vdiv_pkg::*;
(
    input  logic [10:0] ext_op,
    output logic        legal,
    output logic        is_signed,
    output lane_w_e     width,
    output op_kind_e    kind
);
    always_comb begin
        legal     = (ext_op[5:0] == 6'b001011);
        is_signed = ext_op[8];
        width     = LW_WORD;
        kind      = OP_DIV;
        unique case (ext_op[7:6])
            2'b10:   width = LW_WORD;
            2'b11:   width = LW_DWORD;
            2'b00:   width = LW_QUAD;
            default: legal = 1'b0;
        endcase
        unique case (ext_op[10:9])
            2'b00:   kind = OP_DIV;
            2'b01:   kind = OP_DIVE;
            2'b11:   kind = OP_MOD;
            default: legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/vdiv_lane_prep.sv
module vdiv_lane_prep
    import vdiv_pkg::*;
#(
    parameter int DATA_W = 128
) (
    input  logic [DATA_W-1:0] elem_a,
    input  logic [DATA_W-1:0] elem_b,
    input  logic [DATA_W-1:0] lane_mask,
    input  logic              is_signed,
    input  lane_w_e           width,
    input  op_kind_e          kind,
    output logic [DATA_W-1:0] mag_a,
    output logic [DATA_W-1:0] mag_b,
    output logic              neg_q,
    output logic              neg_r,
    output logic              special,
    output logic [DATA_W-1:0] special_val
);
    logic [DATA_W-1:0] min_val;
    logic              a_neg, b_neg;

    always_comb begin
        min_val = lane_mask ^ (lane_mask >> 1);
        a_neg   = is_signed && ((elem_a & min_val) != '0);
        b_neg   = is_signed && ((elem_b & min_val) != '0);
        mag_a   = a_neg ? ((~elem_a + 1'b1) & lane_mask) : elem_a;
        mag_b   = b_neg ? ((~elem_b + 1'b1) & lane_mask) : elem_b;
        neg_q   = a_neg ^ b_neg;
        neg_r   = a_neg;
        special = (elem_b == '0) ||
                  (is_signed && (elem_a == min_val) && (elem_b == lane_mask));
        if (kind == OP_MOD || (kind == OP_DIVE && width == LW_WORD)) begin
            special_val = '0;
        end else begin
            special_val = elem_a;
        end
    end
endmodule

// File: rtl/vdiv_restoring.sv
module vdiv_restoring #(
    parameter int DATA_W = 128,
    localparam int DVD_W = 2 * DATA_W,
    localparam int CNT_W = $clog2(DVD_W) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DVD_W-1:0]  dvd_in,
    input  logic [DATA_W-1:0] dsr_in,
    input  logic [CNT_W-1:0]  iters,
    output logic [DATA_W-1:0] quot,
    output logic [DATA_W-1:0] rem,
    output logic              active
);
    logic [DVD_W-1:0]  dvd_q;
    logic [DATA_W-1:0] dsr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W:0]   trial, diff;
    logic              fits;

    always_comb begin
        trial = {rem, dvd_q[DVD_W-1]};
        diff  = trial - {1'b0, dsr_q};
        fits  = (trial >= {1'b0, dsr_q});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dvd_q <= '0;
            dsr_q <= '0;
            cnt_q <= '0;
            rem   <= '0;
            quot  <= '0;
        end else if (load) begin
            dvd_q <= dvd_in;
            dsr_q <= dsr_in;
            cnt_q <= iters;
            rem   <= '0;
            quot  <= '0;
        end else if (cnt_q != '0) begin
            rem   <= fits ? diff[DATA_W-1:0] : trial[DATA_W-1:0];
            quot  <= {quot[DATA_W-2:0], fits};
            dvd_q <= dvd_q << 1;
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign active = (cnt_q != '0);

    AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (rem < dsr_q)); // R3
    AST_DIVISOR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (dsr_in != '0)); // R6
endmodule

// File: rtl/vdiv_unit.sv
module vdiv_unit
    import vdiv_pkg::*;
#(
    parameter int DATA_W = 128,
    localparam int DVD_W = 2 * DATA_W,
    localparam int CNT_W = $clog2(DVD_W) + 1,
    localparam int LB_W  = $clog2(DATA_W) + 1,
    localparam int LI_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [10:0]       ext_op,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    output logic              busy,
    output logic              done,
    output logic              illegal,
    output logic [DATA_W-1:0] result
);
    state_e            state_q, state_d;
    logic              dec_legal, dec_signed;
    lane_w_e           dec_width, width_q;
    op_kind_e          dec_kind, kind_q;
    logic              signed_q;
    logic [DATA_W-1:0] opa_q, opb_q, lane_val_q;
    logic [LI_W-1:0]   lane_idx_q, last_idx;
    logic [LB_W-1:0]   lane_bits, lane_shift;
    logic [DATA_W-1:0] lane_mask, elem_a, elem_b;
    logic [DATA_W-1:0] mag_a, mag_b, special_val, quot, rem, lane_res;
    logic              neg_q, neg_r, special, core_active, core_load;
    logic [DVD_W-1:0]  dvd_load;
    logic [CNT_W-1:0]  iters;

    vdiv_decode u_decode (
        .ext_op(ext_op), .legal(dec_legal), .is_signed(dec_signed),
        .width(dec_width), .kind(dec_kind)
    );

    always_comb begin
        unique case (width_q)
            LW_WORD:  begin lane_bits = LB_W'(DATA_W / 4); last_idx = 2'd3; end
            LW_DWORD: begin lane_bits = LB_W'(DATA_W / 2); last_idx = 2'd1; end
            default:  begin lane_bits = LB_W'(DATA_W);     last_idx = 2'd0; end
        endcase
        lane_mask  = {DATA_W{1'b1}} >> (LB_W'(DATA_W) - lane_bits);
        lane_shift = LB_W'(lane_idx_q) * lane_bits;
        elem_a     = (opa_q >> lane_shift) & lane_mask;
        elem_b     = (opb_q >> lane_shift) & lane_mask;
        iters      = (kind_q == OP_DIVE) ? CNT_W'({lane_bits, 1'b0}) : CNT_W'(lane_bits);
        dvd_load   = {mag_a, {DATA_W{1'b0}}} << (LB_W'(DATA_W) - lane_bits);
        if (kind_q == OP_MOD) begin
            lane_res = (neg_r ? (~rem + 1'b1) : rem) & lane_mask;
        end else begin
            lane_res = (neg_q ? (~quot + 1'b1) : quot) & lane_mask;
        end
    end

    vdiv_lane_prep #(.DATA_W(DATA_W)) u_prep (
        .elem_a(elem_a), .elem_b(elem_b), .lane_mask(lane_mask),
        .is_signed(signed_q), .width(width_q), .kind(kind_q),
        .mag_a(mag_a), .mag_b(mag_b), .neg_q(neg_q), .neg_r(neg_r),
        .special(special), .special_val(special_val)
    );

    assign core_load = (state_q == S_SETUP) && !special;

    vdiv_restoring #(.DATA_W(DATA_W)) u_core (
        .clk(clk), .rst_n(rst_n), .load(core_load), .dvd_in(dvd_load),
        .dsr_in(mag_b), .iters(iters), .quot(quot), .rem(rem),
        .active(core_active)
    );

    // Next-state logic and state register
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start) state_d = dec_legal ? S_SETUP : S_DONE;
            S_SETUP: state_d = special ? S_WRITE : S_ITER;
            S_ITER:  if (!core_active) state_d = S_WRITE;
            S_WRITE: state_d = (lane_idx_q == last_idx) ? S_DONE : S_SETUP;
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Output and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            width_q    <= LW_WORD;
            kind_q     <= OP_DIV;
            signed_q   <= 1'b0;
            opa_q      <= '0;
            opb_q      <= '0;
            lane_idx_q <= '0;
            lane_val_q <= '0;
            result     <= '0;
            illegal    <= 1'b0;
        end else begin
            unique case (state_q)
                S_IDLE: if (start) begin
                    width_q    <= dec_width;
                    kind_q     <= dec_kind;
                    signed_q   <= dec_signed;
                    opa_q      <= src_a;
                    opb_q      <= src_b;
                    lane_idx_q <= '0;
                    result     <= '0;
                    illegal    <= !dec_legal;
                end
                S_SETUP: if (special) lane_val_q <= special_val;
                S_ITER:  if (!core_active) lane_val_q <= lane_res;
                S_WRITE: begin
                    result     <= (result & ~(lane_mask << lane_shift)) | (lane_val_q << lane_shift);
                    lane_idx_q <= lane_idx_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign busy = (state_q != S_IDLE);
    assign done = (state_q == S_DONE);

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_START_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy); // R8
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(result)); // R8
    AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (result == '0)); // R2
    AST_ILLEGAL_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !dec_legal) |=> (done && illegal)); // R2
endmodule

// File: tb/vdiv_unit_bench.sv
module vdiv_unit_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [10:0]  ext_op = '0;
    logic [127:0] src_a = '0, src_b = '0;
    logic         busy, done, illegal;
    logic [127:0] result;
    int           checks = 0, errors = 0;

    always #10 clk = ~clk;

    vdiv_unit u_vdiv_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .ext_op(ext_op),
        .src_a(src_a), .src_b(src_b), .busy(busy), .done(done),
        .illegal(illegal), .result(result)
    );

    function automatic logic [10:0] mk_op(logic [1:0] kd, logic sg, logic [1:0] wd);
        return {kd, sg, wd, 6'b001011};
    endfunction

    function automatic logic [127:0] ref_lane(logic [127:0] a_in, logic [127:0] b_in,
                                              int w, bit sgn, int kd);
        logic [127:0] mask, a, b, minv, ma, mb, res;
        logic [255:0] dvd, q, r;
        bit an, bn;
        mask = (w == 128) ? '1 : ((128'd1 << w) - 1);
        a = a_in & mask;
        b = b_in & mask;
        minv = mask ^ (mask >> 1);
        an = sgn && a[w-1];
        bn = sgn && b[w-1];
        if (b == '0 || (sgn && a == minv && b == mask)) begin
            if (kd == 3) return '0;
            if (kd == 1 && w == 32) return '0;
            return a;
        end
        ma = an ? ((~a + 1) & mask) : a;
        mb = bn ? ((~b + 1) & mask) : b;
        dvd = (kd == 1) ? ({128'd0, ma} << w) : {128'd0, ma};
        q = dvd / {128'd0, mb};
        r = dvd % {128'd0, mb};
        if (kd == 3) res = an ? (~r[127:0] + 1) : r[127:0];
        else         res = (an ^ bn) ? (~q[127:0] + 1) : q[127:0];
        return res & mask;
    endfunction

    function automatic logic [127:0] ref_vec(logic [10:0] op, logic [127:0] a, logic [127:0] b);
        int w, kd;
        logic [127:0] out, mask;
        w = (op[7:6] == 2'b10) ? 32 : (op[7:6] == 2'b11) ? 64 : 128;
        kd = int'(op[10:9]);
        mask = (w == 128) ? '1 : ((128'd1 << w) - 1);
        out = '0;
        for (int i = 0; i < 128 / w; i++) begin
            out |= (ref_lane(a >> (i * w), b >> (i * w), w, op[8], kd) & mask) << (i * w);
        end
        return out;
    endfunction

    task automatic chk(bit ok, string req, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_op(logic [10:0] op, logic [127:0] a, logic [127:0] b,
                          bit exp_ill, string req, bit poke);
        logic [127:0] exp;
        int n;
        exp = exp_ill ? '0 : ref_vec(op, a, b);
        @(negedge clk);
        ext_op = op; src_a = a; src_b = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R8 busy after start", {127'd0, busy}, 128'd1);
        if (poke) begin
            ext_op = mk_op(2'b11, 1'b0, 2'b10); src_a = ~a; src_b = 128'd3; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        n = 0;
        while (!done && n < 3000) begin
            @(negedge clk);
            n++;
        end
        chk(result == exp, req, result, exp);
        chk(illegal == exp_ill, {req, " illegal flag"}, {127'd0, illegal}, {127'd0, exp_ill});
        @(negedge clk);
        chk(done == 1'b0, "R8 done one cycle", {127'd0, done}, 128'd0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%h expected=%h", 128'd0, 128'd1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [127:0] ra, rb;
        logic [1:0] kds [3];
        logic [1:0] wds [3];
        kds = '{2'b00, 2'b01, 2'b11};
        wds = '{2'b10, 2'b11, 2'b00};
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(busy == 0, "R9 busy", {127'd0, busy}, 0);
        chk(done == 0, "R9 done", {127'd0, done}, 0);
        chk(illegal == 0, "R9 illegal", {127'd0, illegal}, 0);
        chk(result == 0, "R9 result", result, 0);
        rst_n = 1'b1;

        // R1 decode of a signed word divide, R3 unsigned word lanes
        run_op(mk_op(2'b00, 1'b1, 2'b10), {32'd100, 32'hFFFF_FFF9, 32'd50, 32'd9},
               {32'd7, 32'd2, 32'hFFFF_FFFB, 32'd3}, 0, "R1 signed word divide", 0);
        run_op(mk_op(2'b00, 1'b0, 2'b10), {32'd100, 32'd7, 32'hFFFF_FFFF, 32'd0},
               {32'd7, 32'd100, 32'd16, 32'd5}, 0, "R3 unsigned word divide", 0);
        run_op(mk_op(2'b11, 1'b0, 2'b11), {64'd1000, 64'hFFFF_FFFF_FFFF_FFFF},
               {64'd33, 64'd10}, 0, "R3 unsigned dword modulo", 0);
        run_op(mk_op(2'b00, 1'b0, 2'b00), {64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321},
               {64'd0, 64'hDEAD_BEEF}, 0, "R3 unsigned quad divide", 0);
        // R4 signed rounding and remainder sign
        run_op(mk_op(2'b11, 1'b1, 2'b10), {32'hFFFF_FFF9, 32'd7, 32'hFFFF_FFF9, 32'd7},
               {32'd2, 32'hFFFF_FFFE, 32'hFFFF_FFFE, 32'd2}, 0, "R4 signed word modulo", 0);
        run_op(mk_op(2'b00, 1'b1, 2'b00), -128'd1001, 128'd10, 0, "R4 signed quad divide", 0);
        // R5 extended divide
        run_op(mk_op(2'b01, 1'b0, 2'b10), {32'd1, 32'd1, 32'd5, 32'd2},
               {32'd3, 32'd1, 32'd4, 32'd7}, 0, "R5 unsigned word extended", 0);
        run_op(mk_op(2'b01, 1'b1, 2'b11), {-64'd3, 64'd1}, {64'd7, -64'd4}, 0,
               "R5 signed dword extended", 0);
        run_op(mk_op(2'b01, 1'b0, 2'b00), 128'd1, 128'd3, 0, "R5 unsigned quad extended", 0);
        // R6 zero divisor and overflow
        run_op(mk_op(2'b00, 1'b1, 2'b10), {32'h8000_0000, 32'd77, 32'd5, 32'h8000_0000},
               {32'hFFFF_FFFF, 32'd0, 32'd2, 32'd1}, 0, "R6 word divide special", 0);
        run_op(mk_op(2'b11, 1'b1, 2'b11), {64'h8000_0000_0000_0000, 64'd55},
               {64'hFFFF_FFFF_FFFF_FFFF, 64'd0}, 0, "R6 dword modulo special", 0);
        run_op(mk_op(2'b00, 1'b1, 2'b00), {1'b1, 127'd0}, '1, 0, "R6 quad overflow divide", 0);
        run_op(mk_op(2'b11, 1'b0, 2'b00), 128'd12345, 128'd0, 0, "R6 quad modulo zero", 0);
        // R7 extended special cases
        run_op(mk_op(2'b01, 1'b1, 2'b10), {32'd9, 32'h8000_0000, 32'd4, 32'd6},
               {32'd0, 32'hFFFF_FFFF, 32'd0, 32'd3}, 0, "R7 word extended special", 0);
        run_op(mk_op(2'b01, 1'b0, 2'b11), {64'd42, 64'd5}, {64'd0, 64'd9}, 0,
               "R7 dword extended special", 0);
        run_op(mk_op(2'b01, 1'b1, 2'b00), {1'b1, 127'd0}, '1, 0, "R7 quad extended special", 0);
        // R2 unsupported opcodes
        run_op({2'b10, 1'b0, 2'b10, 6'b001011}, '1, 128'd3, 1, "R2 kind field 10", 0);
        run_op({2'b00, 1'b0, 2'b01, 6'b001011}, '1, 128'd3, 1, "R2 width field 01", 0);
        run_op({2'b00, 1'b0, 2'b10, 6'b001010}, '1, 128'd3, 1, "R2 low bits", 0);
        // R8 start while busy ignored
        run_op(mk_op(2'b00, 1'b0, 2'b11), {64'd999, 64'd500}, {64'd4, 64'd7}, 0,
               "R8 start while busy", 1);
        @(negedge clk);
        ext_op = mk_op(2'b00, 1'b0, 2'b10);
        src_a = '1;
        repeat (3) @(negedge clk);
        chk(result == ref_vec(mk_op(2'b00, 1'b0, 2'b11), {64'd999, 64'd500}, {64'd4, 64'd7}),
            "R8 result held idle", result,
            ref_vec(mk_op(2'b00, 1'b0, 2'b11), {64'd999, 64'd500}, {64'd4, 64'd7}));

        // Random mix
        for (int k = 0; k < 3; k++) begin
            for (int wi = 0; wi < 3; wi++) begin
                for (int s = 0; s < 2; s++) begin
                    for (int t = 0; t < 6; t++) begin
                        ra = {$urandom, $urandom, $urandom, $urandom};
                        rb = {$urandom, $urandom, $urandom, $urandom} >> $urandom_range(0, 120);
                        if (t == 5) rb = '0;
                        run_op(mk_op(kds[k], 1'(s), wds[wi]), ra, rb, 0,
                               (k == 1) ? "R5 random extended" :
                               (s == 1) ? "R4 random signed" : "R3 random unsigned", 0);
                    end
                end
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule